// File: doc/BRIEF.md
# H-Bridge Gate Command Logic

This block turns four digital switch commands (one low-side and one high-side command for each of two half-bridges, A and B) into four gate-enable outputs. It settles conflicting commands so that the two switches of one half are never on together, and it holds back every turn-on by a dead time counted in clock cycles. The high-side dead time and the low-side dead time are separate inputs. Turn-off is never delayed. One disable input covers both halves and overrides all commands.

The block also sequences the high-side drivers. After reset the high-side outputs stay off until disable has been asserted at least once. Each time disable is released, both low-side outputs give a fixed-width refresh pulse. The high-side outputs are allowed on again only after a longer interval has passed. If the high-side command of a half is tied high, the low-side command alone switches that half as a complementary pair, with dead time on both edges.

Top module: `hbg_top`

## Requirements
- R1: When disable is sampled high at a clock edge, all four gate outputs are low after that edge, whatever the commands are.
- R2: In a half whose low-side command is high, the high-side output is low after every edge that samples it. The low-side output turns on after the low-side dead time.
- R3: In a half with its low-side command low and its high-side command high, outside the blocked periods, only the high-side output turns on, after the high-side dead time.
- R4: In a half with both commands low, both outputs are low after the next edge.
- R5: An output turns off at the first edge that samples its command (or its permission) gone. No dead time is added on turn-off.
- R6: With dead time D, an output rises at the edge D counted from the first edge that sees its request, edge 0 being that first edge. A request that lasts D or fewer edges never shows at the output.
- R7: With the high-side command held high, a half's two outputs follow the low-side command as a complementary pair, with the low-side and high-side dead times inserted.
- R8: After reset all outputs are low. The high-side outputs stay low until disable has been high at least once.
- R9: Count the first edge that samples disable low after a disabled period as edge 0. Both low-side outputs are then high after edges 1 to REFRESH_CYC, so a low-side output whose command is low gives a pulse exactly REFRESH_CYC cycles wide.
- R10: On the same count, a high-side output whose request stays active rises at edge UPEN_CYC+1+hi_dly, and not earlier.
- R11: The low-side and high-side outputs of one half are never high in the same cycle.
- R12: The two halves act independently. They share only disable, the dead-time settings and the release sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis | input | 1 | Disable for both halves, active high |
| lo_cmd | input | 2 | Low-side commands, bit 0 half A, bit 1 half B |
| hi_cmd | input | 2 | High-side commands, bit 0 half A, bit 1 half B |
| hi_dly | input | DLY_W | High-side turn-on dead time in cycles |
| lo_dly | input | DLY_W | Low-side turn-on dead time in cycles |
| lo_gate | output | 2 | Low-side gate enables, bit 0 half A, bit 1 half B |
| hi_gate | output | 2 | High-side gate enables, bit 0 half A, bit 1 half B |

## Verification
A wrong release-sequencer state shows at the ports within one cycle of a disable release. The refresh pulse would start on the wrong edge or have the wrong width, or a high-side gate would rise before edge UPEN_CYC+1+hi_dly. A dead-time counter that is off by one moves a gate's rising edge by one cycle, and a turn-off that goes through the delay path leaves a gate high one cycle too long. A broken priority or arming state makes a high-side gate rise while its half's low-side command is high, or before any disable. The cycle-accurate comparison catches these in the cycle they occur.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int NUM_HALVES = 2;

    typedef enum logic [2:0] {
        SQ_UNARMED,
        SQ_OFF,
        SQ_REFRESH,
        SQ_HOLD,
        SQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } half_req_t;

    // Priority: disable block first, then low-side command over high-side.
    function automatic half_req_t resolve(input logic blk, input logic hi_ok,
                                          input logic lo_c, input logic hi_c);
        half_req_t r;
        r.lo = !blk && lo_c;
        r.hi = !blk && hi_ok && hi_c && !lo_c;
        return r;
    endfunction

endpackage

// File: rtl/hbg_seq.sv
module hbg_seq
    import hbg_pkg::*;
#(
    parameter int REFRESH_CYC = 65,
    parameter int UPEN_CYC    = 84
) (
    input  logic clk,
    input  logic rst,
    input  logic dis,
    output logic blk,
    output logic lo_force,
    output logic hi_ok
);
    localparam int CW = $clog2(UPEN_CYC + 1);
    localparam logic [CW-1:0] REF_LAST = CW'(REFRESH_CYC - 1);
    localparam logic [CW-1:0] UPEN_LAST = CW'(UPEN_CYC - 1);

    seq_state_e st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_UNARMED;
            cnt <= '0;
        end else if (dis) begin
            st  <= SQ_OFF;
            cnt <= '0;
        end else begin
            case (st)
                SQ_OFF: begin
                    st  <= SQ_REFRESH;
                    cnt <= '0;
                end
                SQ_REFRESH: begin
                    if (cnt == REF_LAST) st <= SQ_HOLD;
                    cnt <= cnt + 1'b1;
                end
                SQ_HOLD: begin
                    if (cnt == UPEN_LAST) st <= SQ_RUN;
                    cnt <= cnt + 1'b1;
                end
                default: begin
                    st  <= st;
                    cnt <= cnt;
                end
            endcase
        end
    end

    assign blk      = dis || (st == SQ_OFF);
    assign lo_force = (st == SQ_REFRESH) && !dis;
    assign hi_ok    = (st == SQ_RUN);

endmodule

// File: rtl/hbg_ondelay.sv
module hbg_ondelay #(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             force_on,
    input  logic [DLY_W-1:0] dly,
    output logic             gate
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= 1'b0;
            cnt  <= '0;
        end else if (force_on) begin
            gate <= 1'b1;
            cnt  <= '0;
        end else if (!req) begin
            gate <= 1'b0;
            cnt  <= '0;
        end else if (!gate) begin
            if (cnt >= dly) gate <= 1'b1;
            else            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hbg_half.sv
module hbg_half
    import hbg_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk,
    input  logic             lo_force,
    input  logic             hi_ok,
    input  logic             lo_c,
    input  logic             hi_c,
    input  logic [DLY_W-1:0] hi_dly,
    input  logic [DLY_W-1:0] lo_dly,
    output logic             lo_g,
    output logic             hi_g
);
    half_req_t req;

    always_comb req = resolve(blk, hi_ok, lo_c, hi_c);

    hbg_ondelay #(.DLY_W(DLY_W)) u_lo (
        .clk(clk), .rst(rst), .req(req.lo), .force_on(lo_force),
        .dly(lo_dly), .gate(lo_g)
    );

    hbg_ondelay #(.DLY_W(DLY_W)) u_hi (
        .clk(clk), .rst(rst), .req(req.hi), .force_on(1'b0),
        .dly(hi_dly), .gate(hi_g)
    );

endmodule

// File: rtl/hbg_top.sv
module hbg_top
    import hbg_pkg::*;
#(
    parameter int DLY_W       = 6,
    parameter int REFRESH_CYC = 65,
    parameter int UPEN_CYC    = 84
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dis,
    input  logic [NUM_HALVES-1:0] lo_cmd,
    input  logic [NUM_HALVES-1:0] hi_cmd,
    input  logic [DLY_W-1:0]      hi_dly,
    input  logic [DLY_W-1:0]      lo_dly,
    output logic [NUM_HALVES-1:0] lo_gate,
    output logic [NUM_HALVES-1:0] hi_gate
);
    logic blk, lo_force, hi_ok;

    hbg_seq #(.REFRESH_CYC(REFRESH_CYC), .UPEN_CYC(UPEN_CYC)) u_seq (
        .clk(clk), .rst(rst), .dis(dis),
        .blk(blk), .lo_force(lo_force), .hi_ok(hi_ok)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        hbg_half #(.DLY_W(DLY_W)) u_half (
            .clk(clk), .rst(rst), .blk(blk), .lo_force(lo_force),
            .hi_ok(hi_ok), .lo_c(lo_cmd[h]), .hi_c(hi_cmd[h]),
            .hi_dly(hi_dly), .lo_dly(lo_dly),
            .lo_g(lo_gate[h]), .hi_g(hi_gate[h])
        );
    end

endmodule

// File: rtl/hbg_chk.sv
module hbg_chk (
    input logic       clk,
    input logic       rst,
    input logic       dis,
    input logic [1:0] lo_cmd,
    input logic [1:0] hi_cmd,
    input logic [1:0] lo_gate,
    input logic [1:0] hi_gate
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)      armed <= 1'b0;
        else if (dis) armed <= 1'b1;
    end

    // R11
    no_overlap_a_chk: assert property (@(posedge clk) disable iff (rst)
        !(lo_gate[0] && hi_gate[0]));

    // R11
    no_overlap_b_chk: assert property (@(posedge clk) disable iff (rst)
        !(lo_gate[1] && hi_gate[1]));

    // R1
    dis_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(dis) |-> (lo_gate == 2'b00 && hi_gate == 2'b00));

    // R2
    lo_priority_a_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lo_cmd[0]) |-> !hi_gate[0]);

    // R2
    lo_priority_b_chk: assert property (@(posedge clk) disable iff (rst)
        $past(lo_cmd[1]) |-> !hi_gate[1]);

    // R5
    hi_fast_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hi_cmd == 2'b00) |-> hi_gate == 2'b00);

    // R8
    unarmed_hi_off_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> hi_gate == 2'b00);

endmodule

bind hbg_top hbg_chk u_chk (
    .clk(clk), .rst(rst), .dis(dis), .lo_cmd(lo_cmd), .hi_cmd(hi_cmd),
    .lo_gate(lo_gate), .hi_gate(hi_gate)
);

// File: tb/sim_hbg_top.sv
module sim_hbg_top;
    localparam int DLY_W = 6;
    localparam int REF_C = 65;
    localparam int UPEN_C = 84;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dis = 1'b0;
    logic [1:0] lo_cmd = 2'b00;
    logic [1:0] hi_cmd = 2'b00;
    logic [DLY_W-1:0] hi_dly = 6'd5;
    logic [DLY_W-1:0] lo_dly = 6'd3;
    logic [1:0] lo_gate, hi_gate;

    int nchk = 0;
    int nerr = 0;
    bit wd = 1'b0;
    string phase = "R8";

    hbg_top #(.DLY_W(DLY_W), .REFRESH_CYC(REF_C), .UPEN_CYC(UPEN_C)) u0 (
        .clk(clk), .rst(rst), .dis(dis), .lo_cmd(lo_cmd), .hi_cmd(hi_cmd),
        .hi_dly(hi_dly), .lo_dly(lo_dly), .lo_gate(lo_gate), .hi_gate(hi_gate)
    );

    always #2 clk = ~clk;

    // Cycle model built from the requirements: 0 unarmed,1 off,2 refresh,3 hold,4 run
    int m_st = 0;
    int m_cnt = 0;
    logic [1:0] m_lo = 2'b00, m_hi = 2'b00;
    int c_lo [2];
    int c_hi [2];

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_lo = 2'b00; m_hi = 2'b00;
            for (int h = 0; h < 2; h++) begin c_lo[h] = 0; c_hi[h] = 0; end
        end else begin
            bit blk, frc, ok;
            blk = dis || (m_st == 1);
            frc = (m_st == 2) && !dis;
            ok  = (m_st == 4);
            for (int h = 0; h < 2; h++) begin
                bit lr, hr;
                lr = !blk && lo_cmd[h];
                hr = !blk && ok && hi_cmd[h] && !lo_cmd[h];
                if (frc) begin m_lo[h] = 1'b1; c_lo[h] = 0; end
                else if (!lr) begin m_lo[h] = 1'b0; c_lo[h] = 0; end
                else if (!m_lo[h]) begin
                    if (c_lo[h] >= int'(lo_dly)) m_lo[h] = 1'b1; else c_lo[h]++;
                end
                if (!hr) begin m_hi[h] = 1'b0; c_hi[h] = 0; end
                else if (!m_hi[h]) begin
                    if (c_hi[h] >= int'(hi_dly)) m_hi[h] = 1'b1; else c_hi[h]++;
                end
            end
            if (dis) begin m_st = 1; m_cnt = 0; end
            else if (m_st == 1) begin m_st = 2; m_cnt = 0; end
            else if (m_st == 2) begin if (m_cnt == REF_C - 1) m_st = 3; m_cnt++; end
            else if (m_st == 3) begin if (m_cnt == UPEN_C - 1) m_st = 4; m_cnt++; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) begin
            chk(phase, {28'd0, lo_gate, hi_gate}, {28'd0, m_lo, m_hi});
            chk("R11", {30'd0, lo_gate & hi_gate}, 32'd0);
        end
    endtask

    task automatic run_seq();
        int first_lo, n_lo, first_hi;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R8", {28'd0, lo_gate, hi_gate}, 32'd0);

        phase = "R8";
        hi_cmd = 2'b11;
        repeat (20) tick();
        chk("R8", {30'd0, hi_gate}, 32'd0);

        phase = "R6";
        lo_cmd = 2'b01;
        repeat (3) begin tick(); chk("R6", {30'd0, lo_gate}, 32'd0); end
        tick(); chk("R6", {30'd0, lo_gate}, 32'd1);

        phase = "R5";
        lo_cmd = 2'b00;
        tick(); chk("R5", {30'd0, lo_gate}, 32'd0);

        phase = "R6";
        lo_cmd = 2'b10;
        repeat (2) tick();
        lo_cmd = 2'b00;
        repeat (4) begin tick(); chk("R6", {30'd0, lo_gate}, 32'd0); end

        phase = "R1";
        lo_cmd = 2'b11; hi_cmd = 2'b11; dis = 1'b1;
        repeat (6) begin tick(); chk("R1", {28'd0, lo_gate, hi_gate}, 32'd0); end

        phase = "R9";
        lo_cmd = 2'b00; hi_cmd = 2'b11; dis = 1'b0;
        first_lo = -1; n_lo = 0; first_hi = -1;
        for (int k = 1; k <= 110; k++) begin
            tick();
            if (lo_gate == 2'b11) begin n_lo++; if (first_lo < 0) first_lo = k; end
            if (hi_gate == 2'b11 && first_hi < 0) first_hi = k;
        end
        chk("R9", first_lo, 2);
        chk("R9", n_lo, REF_C);
        chk("R10", first_hi, UPEN_C + 2 + 5);

        phase = "R2";
        lo_cmd = 2'b01;
        tick(); chk("R2", {28'd0, lo_gate, hi_gate}, {28'd0, 2'b00, 2'b10});
        repeat (2) tick();
        tick(); chk("R2", {28'd0, lo_gate, hi_gate}, {28'd0, 2'b01, 2'b10});

        phase = "R3";
        lo_cmd = 2'b00;
        tick(); chk("R3", {28'd0, lo_gate, hi_gate}, {28'd0, 2'b00, 2'b10});
        repeat (5) tick();
        chk("R3", {28'd0, lo_gate, hi_gate}, {28'd0, 2'b00, 2'b11});

        phase = "R4";
        hi_cmd = 2'b00;
        tick(); chk("R4", {28'd0, lo_gate, hi_gate}, 32'd0);

        phase = "R7";
        hi_cmd = 2'b11;
        for (int s = 0; s < 60; s++) begin
            lo_cmd = 2'($urandom_range(0, 3));
            repeat ($urandom_range(1, 12)) tick();
        end

        phase = "R12";
        for (int s = 0; s < 2500; s++) begin
            lo_cmd = 2'($urandom_range(0, 3));
            hi_cmd = 2'($urandom_range(0, 3));
            dis = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 99) == 0) begin
                hi_dly = 6'($urandom_range(0, 9));
                lo_dly = 6'($urandom_range(0, 9));
            end
            repeat ($urandom_range(1, 10)) tick();
        end
        dis = 1'b0;
        repeat (200) tick();
    endtask

    initial begin
        void'($urandom(32'd4242));
        fork
            run_seq();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
        end
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule